// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block produces the system reset for a processor subsystem. Three causes can start a reset. The first is a supply monitor flag that reports undervoltage. The second is an active-low manual push-button input. The third is a watchdog that expects the processor to toggle a heartbeat pin. Each reset is held for a fixed recovery period after its cause goes away, so downstream logic always sees a reset of at least that length.

The watchdog treats either a rising or a falling edge of the heartbeat as a kick. It is held cleared for the whole time reset is asserted and while its enable input is low. The enable input stands in for a heartbeat pin left floating. If the heartbeat stays stuck, the block produces a periodic reset whose period is the watchdog time plus the recovery time.

All periods are parameters in clock cycles. The block runs from one clock and has an asynchronous active-low power-on reset.

Top module: `rst_supervisor`

## Requirements
- R1: A low `vdd_ok` sampled at a clock edge forces `rst_n_out` low after that edge, and the reset stays low while the flag stays low.
- R2: A low `mr_n` sampled at a clock edge forces `rst_n_out` low after that edge, and the reset stays low while the input stays low.
- R3: Once every cause has cleared, reset stays asserted for exactly REC_CYCLES further clock edges. With cause-free inputs first sampled at edge 0, `rst_n_out` rises after edge REC_CYCLES-1. Every reset pulse, including one raised by the watchdog, lasts at least REC_CYCLES cycles.
- R4: If the supply flag goes low during recovery, the recovery count restarts from zero. The count begins again only after the flag returns high.
- R5: With `wd_en` high and reset released, the watchdog trips after WDT_CYCLES clock edges without a kick. A kick is any change of `hb`, seen through a two-flop synchronizer plus one compare flop, so the kick clears the count at the third edge after the change.
- R6: The watchdog count is held at zero while reset is asserted. A stuck heartbeat therefore gives `rst_n_out` low for REC_CYCLES cycles and high for WDT_CYCLES cycles, repeating.
- R7: With `wd_en` low, the watchdog never trips, however long `hb` stays constant.
- R8: `rst_out` is always the complement of `rst_n_out`.
- R9: While `por_n` is low and afterwards, reset is asserted. Recovery counts from zero from the first edge with `por_n` high and `vdd_ok` good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| vdd_ok | input | 1 | Supply monitor flag, 1 = supply above threshold |
| mr_n | input | 1 | Manual push-button reset, active low |
| hb | input | 1 | Processor heartbeat, asynchronous |
| wd_en | input | 1 | Watchdog enable, low holds the watchdog cleared |
| rst_n_out | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |

## Verification
The assertions assume that `vdd_ok`, `mr_n` and `wd_en` are already synchronous to `clk`, because the R1 and R2 properties expect the reset one edge after the cause is sampled. Only `hb` is treated as asynchronous. The stimulus changes every input on the falling clock edge, so each value is stable at the next rising edge. The bench also keeps heartbeat toggles closer together than the watchdog period whenever a trip is not the intended outcome.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // width needed for a counter that spans 0..n-1
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // true when a counter value is the last step of an n-cycle period
  function automatic logic at_limit(input int value, input int n);
    return value == (n - 1);
  endfunction
endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync (
  input  logic clk,
  input  logic por_n,
  input  logic hb,
  output logic kick
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= hb;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // either edge of the synchronized heartbeat
  assign kick = sync_q ^ prev_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int WDT_CYCLES = 50
) (
  input  logic clk,
  input  logic por_n,
  input  logic kick,
  input  logic wd_en,
  input  logic hold,
  output logic trip,
  output logic cnt_zero
);
  localparam int W = sup_pkg::cnt_width(WDT_CYCLES);
  logic [W-1:0] cnt_q;

  assign trip     = wd_en & ~hold & ~kick & sup_pkg::at_limit(int'(cnt_q), WDT_CYCLES);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                             cnt_q <= '0;
    else if (!wd_en || hold || kick || trip) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rec_timer.sv
module rec_timer #(
  parameter int REC_CYCLES = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic cause,
  input  logic trip,
  output logic active,
  output logic done
);
  localparam int W = sup_pkg::cnt_width(REC_CYCLES);
  logic [W-1:0] cnt_q;
  logic         active_q;

  assign active = active_q;
  assign done   = active_q & ~cause & ~trip & sup_pkg::at_limit(int'(cnt_q), REC_CYCLES);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cause || trip) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (done) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int REC_CYCLES = 20,
  parameter int WDT_CYCLES = 50
) (
  input  logic clk,
  input  logic por_n,
  input  logic vdd_ok,
  input  logic mr_n,
  input  logic hb,
  input  logic wd_en,
  output logic rst_n_out,
  output logic rst_out
);
  logic kick, wd_trip, wd_cnt_zero, rst_active, rec_done, level_cause;

  assign level_cause = ~vdd_ok | ~mr_n;

  hb_edge_sync u_sync (
    .clk(clk), .por_n(por_n), .hb(hb), .kick(kick)
  );

  wdt_counter #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk(clk), .por_n(por_n), .kick(kick), .wd_en(wd_en),
    .hold(rst_active), .trip(wd_trip), .cnt_zero(wd_cnt_zero)
  );

  rec_timer #(.REC_CYCLES(REC_CYCLES)) u_rec (
    .clk(clk), .por_n(por_n), .cause(level_cause), .trip(wd_trip),
    .active(rst_active), .done(rec_done)
  );

  assign rst_n_out = ~rst_active;
  assign rst_out   = rst_active;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int REC_CYCLES = 20
) (
  input logic clk,
  input logic por_n,
  input logic vdd_ok,
  input logic mr_n,
  input logic wd_en,
  input logic rst_n_out,
  input logic rst_out,
  input logic wd_trip,
  input logic wd_cnt_zero,
  input logic rst_active
);
  int low_run;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          low_run <= 0;
    else if (!rst_n_out) low_run <= low_run + 1;
    else                 low_run <= 0;
  end

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
    !vdd_ok |=> !rst_n_out);
  assert_manual_low_R2: assert property (@(posedge clk) disable iff (!por_n)
    !mr_n |=> !rst_n_out);
  assert_min_width_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_out) |-> low_run >= REC_CYCLES);
  assert_trip_resets_R5: assert property (@(posedge clk) disable iff (!por_n)
    wd_trip |=> !rst_n_out);
  assert_wdt_held_R6: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |=> wd_cnt_zero);
  assert_wdt_off_R7: assert property (@(posedge clk) disable iff (!por_n)
    !wd_en |-> !wd_trip);
  assert_complement_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_out == !rst_n_out);
endmodule

bind rst_supervisor sup_checker #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .vdd_ok(vdd_ok), .mr_n(mr_n), .wd_en(wd_en),
  .rst_n_out(rst_n_out), .rst_out(rst_out), .wd_trip(wd_trip),
  .wd_cnt_zero(wd_cnt_zero), .rst_active(rst_active)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int REC = 20;
  localparam int WDT = 50;

  logic clk = 1'b0, por_n = 1'b0, vdd_ok = 1'b1, mr_n = 1'b1, hb = 1'b0, wd_en = 1'b0;
  logic rst_n_out, rst_out;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rst_supervisor #(.REC_CYCLES(REC), .WDT_CYCLES(WDT)) u0 (
    .clk(clk), .por_n(por_n), .vdd_ok(vdd_ok), .mr_n(mr_n), .hb(hb),
    .wd_en(wd_en), .rst_n_out(rst_n_out), .rst_out(rst_out)
  );

  typedef struct packed {
    logic        vdd;
    logic        mr;
    logic        en;
    logic        beat;
    logic [15:0] wait_n;
    logic        exp_n;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd5,  1'b0},  // R9 held after power-on
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd14, 1'b0},  // R9 19 edges: still held
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd1,  1'b1},  // R9 released at 20th edge
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd1,  1'b0},  // R1 undervoltage
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd19, 1'b0},  // R3 boundary minus one
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd1,  1'b1},  // R3 release
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd1,  1'b0},  // R2 manual press
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd19, 1'b0},  // R3 after manual
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd1,  1'b1},  // R3 release
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd3,  1'b0},  // R2 held while low
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd15, 1'b0},  // R3 recovering
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd2,  1'b0},  // R4 drop mid-recovery
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd15, 1'b0},  // R4 count restarted
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd4,  1'b0},  // R4 19 edges after return
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd1,  1'b1},  // R4 release
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'd30, 1'b1},  // R5 rising kick
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'd30, 1'b1},  // R5 falling kick
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'd30, 1'b1},  // R5 rising kick
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'd30, 1'b1}   // R5 falling kick
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp_n, input string tag);
    checks++;
    if (rst_n_out !== exp_n) begin
      fails++;
      $display("FAIL %s: rst_n_out=%b expected %b", tag, rst_n_out, exp_n);
    end
    checks++;
    if (rst_out !== ~exp_n) begin
      fails++;
      $display("FAIL R8 (%s): rst_out=%b expected %b", tag, rst_out, ~exp_n);
    end
  endtask

  task automatic check_val(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    int low_len, high_len;
    repeat (3) @(negedge clk);
    check(1'b0, "R9 during power-on");
    por_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      vdd_ok = TBL[i].vdd; mr_n = TBL[i].mr; wd_en = TBL[i].en; hb = TBL[i].beat;
      tick(int'(TBL[i].wait_n));
      check(TBL[i].exp_n, $sformatf("vector %0d", i));
    end

    // R5 exact trip point after the last kick
    hb = 1'b1;
    tick(52);
    check(1'b1, "R5 before trip");
    tick(1);
    check(1'b0, "R5 trip");

    // R6 stuck heartbeat gives REC low / WDT high
    low_len = 1;
    while (rst_n_out == 1'b0 && low_len < 1000) begin tick(1); low_len++; end
    low_len--;
    high_len = 1;
    while (rst_n_out == 1'b1 && high_len < 1000) begin tick(1); high_len++; end
    high_len--;
    check_val(low_len, REC, "R3 watchdog reset width");
    check_val(high_len, WDT, "R6 stuck heartbeat high time");

    // R7 disabled watchdog ignores a stuck heartbeat
    wd_en = 1'b0;
    tick(200);
    check(1'b1, "R7 disabled watchdog");

    // R6 watchdog held during a long manual reset
    wd_en = 1'b1;
    mr_n = 1'b0;
    tick(100);
    check(1'b0, "R2 long press");
    mr_n = 1'b1;
    tick(20);
    check(1'b1, "R6 release after press");
    tick(49);
    check(1'b1, "R6 count started at release");
    tick(1);
    check(1'b0, "R6 trip after full period");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule